// File: doc/BRIEF.md
# Indirect CSR Access Bridge Across Clock Domains

This block lets a host bus reach a bank of up to 256 32-bit control and status registers that run on a separate clock. The host does not address those registers directly. It sees two 32-bit registers of its own: a command word and a data word. To write a far register, the host loads the data word and then writes the command word with the go bit set and the direction bit clear. To read a far register, the host writes the command word with both the go bit and the direction bit set. When the go bit reads back as zero, the fetched value is in the data word.

Each request crosses into the far clock domain through a four-phase level handshake. Both the request and the acknowledge pass through two-flop synchronizers. On the far side, the bridge issues exactly one single-cycle register-port strobe for the request. For a read, it captures the returned word one far cycle after the read strobe. Address, direction and write data stay frozen on the host side until the handshake has completed, so the far side can sample them without further synchronization.

Top module: `csr_sync_bridge`

## Requirements
- R1: After reset, the command word and the data word both read as zero, and no far-side strobe is issued.
- R2: The command word sits at host offset A4h. Reading it returns the go/busy flag in bit 31, the direction in bit 30 (1 = read, 0 = write), the far register address in bits 7:0, and zero in bits 29:8 whatever was written there.
- R3: Writing the command word while idle with bit 31 set starts one access. From the host cycle after that write, bit 31 reads as 1.
- R4: Bit 31 stays at 1 until the request has been acknowledged and the acknowledge has dropped again. This is a full round trip through both synchronizers, so busy lasts at least 8 host cycles.
- R5: Each access produces exactly one far strobe, lasting one far cycle. A write strobe carries the command address and the data word. The write and read strobes are never high together.
- R6: For a read, the far value returned one far cycle after the read strobe is already in the data word in the first host cycle where bit 31 reads 0.
- R7: While bit 31 is set, host writes to the command word or the data word have no effect and start nothing.
- R8: A command write with bit 31 clear stores the direction and the address but starts no access.
- R9: Host offsets other than A4h and A8h read as zero, and writes to them change nothing.
- R10: The data word at host offset A8h can be written and read back while idle. A far write access leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host-side clock |
| hostRstN | input | 1 | Host-side active-low reset |
| hostAddr | input | 8 | Host byte offset for read and write |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostWrData | input | 32 | Host write value |
| hostRdData | output | 32 | Host read value for hostAddr (combinational) |
| farClk | input | 1 | Far register-bank clock |
| farRstN | input | 1 | Far-side active-low reset |
| farAddr | output | 8 | Far register address |
| farWrEn | output | 1 | Far write strobe, one far cycle |
| farWrData | output | 32 | Far write value |
| farRdEn | output | 1 | Far read strobe, one far cycle |
| farRdData | input | 32 | Far read value, valid one far cycle after farRdEn |

## Verification
The bridge is driven with a run of back-to-back writes and reads to the lowest address, the highest address, a middle address and a register never written before. These cases separate a correct address and data path from stuck or swapped fields, and show whether a read returns stale data. Command writes with the go bit clear, and with the reserved bits all set, show that storing fields is distinct from starting an access. A burst of command and data writes sent while busy tells an honoured lock-out from a silently restarted or corrupted access. Strobe counts and busy lengths, measured against a clock with an unrelated period, show whether each request is issued exactly once and waits for the full round trip.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;

  // Strobes from host-side control to host-side datapath
  typedef struct packed {
    logic cmdWe;   // accepted command-word write
    logic dataWe;  // accepted data-word write
    logic rdLoad;  // acknowledge seen: load far capture (reads only)
    logic busy;    // access in flight
  } hostStrb_t;

  typedef enum logic [1:0] {
    H_IDLE,
    H_REQ,
    H_DROP
  } hostState_t;

  typedef enum logic [1:0] {
    F_IDLE,
    F_STROBE,
    F_RDWAIT,
    F_ACKD
  } farState_t;

endpackage

// File: rtl/csr_bridge_ctrl.sv
module csr_bridge_ctrl
  import csr_bridge_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [HOST_AW-1:0] CMD_OFF = 8'hA4,
  parameter logic [HOST_AW-1:0] DATA_OFF = 8'hA8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic               goBit,
  input  logic               farAck,
  output logic               reqLvl,
  output hostStrb_t          strb
);

  hostState_t state;
  logic [SYNC_STAGES-1:0] ackSyncQ;
  logic ackSync;
  logic idle;
  logic start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackSyncQ <= '0;
    else       ackSyncQ <= {ackSyncQ[SYNC_STAGES-2:0], farAck};
  end
  assign ackSync = ackSyncQ[SYNC_STAGES-1];

  assign idle = (state == H_IDLE);

  always_comb begin
    strb.cmdWe  = hostWrEn && (hostAddr == CMD_OFF) && idle;
    strb.dataWe = hostWrEn && (hostAddr == DATA_OFF) && idle;
    strb.rdLoad = (state == H_REQ) && ackSync;
    strb.busy   = !idle;
  end

  assign start = strb.cmdWe && goBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= H_IDLE;
      reqLvl <= 1'b0;
    end else begin
      unique case (state)
        H_IDLE: if (start) begin
          state  <= H_REQ;
          reqLvl <= 1'b1;
        end
        H_REQ: if (ackSync) begin
          state  <= H_DROP;
          reqLvl <= 1'b0;
        end
        H_DROP: if (!ackSync) state <= H_IDLE;
        default: state <= H_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqLvl && !ackSync |=> reqLvl); // R4
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqLvl |-> strb.busy); // R3
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.busy) |-> ($past(!ackSync) && $past(!reqLvl))); // R4

endmodule

// File: rtl/csr_bridge_dp.sv
module csr_bridge_dp
  import csr_bridge_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [HOST_AW-1:0] CMD_OFF = 8'hA4,
  parameter logic [HOST_AW-1:0] DATA_OFF = 8'hA8
) (
  input  logic               clk,
  input  logic               rstN,
  input  hostStrb_t          strb,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWrData,
  input  logic [DATA_W-1:0]  farCapture,
  output logic               dirQ,
  output logic [ADDR_W-1:0]  addrQ,
  output logic [DATA_W-1:0]  dataQ,
  output logic [DATA_W-1:0]  hostRdData
);

  localparam int RSV_W = DATA_W - 2 - ADDR_W;
  localparam int DIR_BIT = DATA_W - 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= 1'b0;
      addrQ <= '0;
    end else if (strb.cmdWe) begin
      dirQ  <= hostWrData[DIR_BIT];
      addrQ <= hostWrData[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    dataQ <= '0;
    else if (strb.dataWe)         dataQ <= hostWrData;
    else if (strb.rdLoad && dirQ) dataQ <= farCapture;
  end

  always_comb begin
    hostRdData = '0;
    if (hostAddr == CMD_OFF)       hostRdData = {strb.busy, dirQ, {RSV_W{1'b0}}, addrQ};
    else if (hostAddr == DATA_OFF) hostRdData = dataQ;
  end

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> ($stable(dirQ) && $stable(addrQ))); // R7
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy && !strb.rdLoad |=> $stable(dataQ)); // R7

endmodule

// File: rtl/csr_bridge_far.sv
module csr_bridge_far
  import csr_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqLvl,
  input  logic              dirIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] farRdData,
  output logic              ackLvl,
  output logic [DATA_W-1:0] rdCap,
  output logic [ADDR_W-1:0] farAddr,
  output logic [DATA_W-1:0] farWrData,
  output logic              farWrEn,
  output logic              farRdEn
);

  farState_t state;
  logic [SYNC_STAGES-1:0] reqSyncQ;
  logic reqSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqSyncQ <= '0;
    else       reqSyncQ <= {reqSyncQ[SYNC_STAGES-2:0], reqLvl};
  end
  assign reqSync = reqSyncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= F_IDLE;
      ackLvl <= 1'b0;
      rdCap  <= '0;
    end else begin
      unique case (state)
        F_IDLE: if (reqSync && !ackLvl) state <= F_STROBE;
        F_STROBE: begin
          if (dirIn) state <= F_RDWAIT;
          else begin
            ackLvl <= 1'b1;
            state  <= F_ACKD;
          end
        end
        F_RDWAIT: begin
          rdCap  <= farRdData;
          ackLvl <= 1'b1;
          state  <= F_ACKD;
        end
        F_ACKD: if (!reqSync) begin
          ackLvl <= 1'b0;
          state  <= F_IDLE;
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  assign farWrEn   = (state == F_STROBE) && !dirIn;
  assign farRdEn   = (state == F_STROBE) && dirIn;
  assign farAddr   = addrIn;
  assign farWrData = dataIn;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({farWrEn, farRdEn})); // R5
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (farWrEn || farRdEn) |=> !(farWrEn || farRdEn)); // R5
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackLvl) |-> reqSync); // R4
  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ackLvl |=> $stable(rdCap)); // R6

endmodule

// File: rtl/csr_sync_bridge.sv
module csr_sync_bridge
  import csr_bridge_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [HOST_AW-1:0] CMD_OFF = 8'hA4,
  parameter logic [HOST_AW-1:0] DATA_OFF = 8'hA8
) (
  input  logic               hostClk,
  input  logic               hostRstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  hostRdData,
  input  logic               farClk,
  input  logic               farRstN,
  output logic [ADDR_W-1:0]  farAddr,
  output logic               farWrEn,
  output logic [DATA_W-1:0]  farWrData,
  output logic               farRdEn,
  input  logic [DATA_W-1:0]  farRdData
);

  hostStrb_t strb;
  logic reqLvl;
  logic ackLvl;
  logic dirQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdCap;

  csr_bridge_ctrl #(
    .HOST_AW(HOST_AW), .SYNC_STAGES(SYNC_STAGES),
    .CMD_OFF(CMD_OFF), .DATA_OFF(DATA_OFF)
  ) u_ctrl (
    .clk(hostClk), .rstN(hostRstN),
    .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .goBit(hostWrData[DATA_W-1]), .farAck(ackLvl),
    .reqLvl(reqLvl), .strb(strb)
  );

  csr_bridge_dp #(
    .HOST_AW(HOST_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CMD_OFF(CMD_OFF), .DATA_OFF(DATA_OFF)
  ) u_dp (
    .clk(hostClk), .rstN(hostRstN), .strb(strb),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .farCapture(rdCap),
    .dirQ(dirQ), .addrQ(addrQ), .dataQ(dataQ), .hostRdData(hostRdData)
  );

  csr_bridge_far #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_far (
    .clk(farClk), .rstN(farRstN),
    .reqLvl(reqLvl), .dirIn(dirQ), .addrIn(addrQ), .dataIn(dataQ),
    .farRdData(farRdData), .ackLvl(ackLvl), .rdCap(rdCap),
    .farAddr(farAddr), .farWrData(farWrData),
    .farWrEn(farWrEn), .farRdEn(farRdEn)
  );

endmodule

// File: tb/csr_sync_bridge_bench.sv
`timescale 1ns/1ps
module csr_sync_bridge_bench;

  localparam logic [7:0] CMD = 8'hA4;
  localparam logic [7:0] DAT = 8'hA8;
  localparam int NVEC = 11;
  // {isRead, farAddress, writeValue}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 8'h05, 32'hDEADBEEF},
    {1'b1, 8'h05, 32'h0},
    {1'b0, 8'hFF, 32'h12345678},
    {1'b0, 8'h00, 32'hA5A5A5A5},
    {1'b1, 8'hFF, 32'h0},
    {1'b1, 8'h00, 32'h0},
    {1'b0, 8'h05, 32'h0F0F0F0F},
    {1'b1, 8'h05, 32'h0},
    {1'b1, 8'h80, 32'h0},
    {1'b0, 8'h80, 32'hFFFFFFFF},
    {1'b1, 8'h80, 32'h0}
  };

  logic hostClk = 0, farClk = 0;
  logic hostRstN = 0, farRstN = 0;
  logic [7:0] hostAddr = '0;
  logic hostWrEn = 0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [7:0] farAddr;
  logic farWrEn, farRdEn;
  logic [31:0] farWrData;
  logic [31:0] farRdData = '0;

  logic [31:0] farMem [256];
  logic [31:0] refMem [256];
  int strobeCnt = 0;
  int nCheck = 0, nFail = 0;
  bit finished = 0;

  always #4 hostClk = ~hostClk;
  always #5.5 farClk = ~farClk;

  csr_sync_bridge u_csr_sync_bridge (
    .hostClk(hostClk), .hostRstN(hostRstN), .hostAddr(hostAddr),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .farClk(farClk), .farRstN(farRstN), .farAddr(farAddr),
    .farWrEn(farWrEn), .farWrData(farWrData), .farRdEn(farRdEn),
    .farRdData(farRdData)
  );

  // Far register bank model: one-cycle read latency
  always @(posedge farClk) begin
    if (farWrEn) farMem[farAddr] <= farWrData;
    if (farRdEn) farRdData <= farMem[farAddr];
    if (farWrEn || farRdEn) strobeCnt <= strobeCnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge hostClk);
    hostAddr = a; hostWrData = d; hostWrEn = 1;
    @(negedge hostClk);
    hostWrEn = 0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    hostAddr = CMD;
    #1;
    while (hostRdData[31] && cyc < 2000) begin
      @(negedge hostClk);
      #1;
      cyc++;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  endtask

  initial begin
    #1200000;
    nCheck++; nFail++;
    $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
    finish();
  end

  initial begin
    logic [31:0] rd;
    int cyc, base;
    for (int i = 0; i < 256; i++) begin
      farMem[i] = 32'hC0DE0000 ^ (32'(i) * 32'h01000193);
      refMem[i] = farMem[i];
    end
    repeat (5) @(negedge hostClk);
    hostRstN = 1; farRstN = 1;
    repeat (3) @(negedge hostClk);

    // R1 reset state
    hostRead(CMD, rd); check(rd == 0, "R1 cmd", rd, 0);
    hostRead(DAT, rd); check(rd == 0, "R1 data", rd, 0);
    check(strobeCnt == 0, "R1 strobes", strobeCnt, 0);

    // R10 data word read/write while idle
    hostWrite(DAT, 32'h11223344);
    hostRead(DAT, rd); check(rd == 32'h11223344, "R10 data rw", rd, 32'h11223344);

    // R8 command write without go bit
    base = strobeCnt;
    hostWrite(CMD, 32'h40000033);
    hostRead(CMD, rd); check(rd == 32'h40000033, "R8 fields stored", rd, 32'h40000033);
    repeat (40) @(negedge hostClk);
    check(strobeCnt == base, "R8 no access", strobeCnt, base);

    // R2 reserved bits read zero
    hostWrite(CMD, 32'h3FFFFF7E);
    hostRead(CMD, rd); check(rd == 32'h0000007E, "R2 layout", rd, 32'h0000007E);

    // R9 unmapped offset
    hostWrite(8'h10, 32'hFFFFFFFF);
    hostRead(8'h10, rd); check(rd == 0, "R9 unmapped read", rd, 0);
    hostRead(CMD, rd); check(rd == 32'h0000007E, "R9 cmd untouched", rd, 32'h0000007E);
    hostRead(DAT, rd); check(rd == 32'h11223344, "R9 data untouched", rd, 32'h11223344);

    // R3 start, then R7 writes while busy
    base = strobeCnt;
    hostWrite(CMD, 32'h8000007E);
    hostRead(CMD, rd); check(rd == 32'h8000007E, "R3 busy set", rd, 32'h8000007E);
    hostWrite(DAT, 32'hBAD0BAD0);
    hostWrite(CMD, 32'hC0000001);
    waitIdle(cyc);
    hostRead(CMD, rd); check(rd == 32'h0000007E, "R7 cmd ignored", rd, 32'h0000007E);
    hostRead(DAT, rd); check(rd == 32'h11223344, "R7 data ignored", rd, 32'h11223344);
    repeat (20) @(negedge hostClk);
    check(strobeCnt == base + 1, "R7 single access", strobeCnt, base + 1);
    check(farMem[8'h7E] == 32'h11223344, "R5 write value", farMem[8'h7E], 32'h11223344);
    check(farMem[8'h01] == refMem[8'h01], "R7 no stray write", farMem[8'h01], refMem[8'h01]);
    refMem[8'h7E] = 32'h11223344;

    // Vector table: back-to-back writes and reads
    for (int v = 0; v < NVEC; v++) begin
      logic isRd;
      logic [7:0] a;
      logic [31:0] d;
      {isRd, a, d} = VEC[v];
      base = strobeCnt;
      if (!isRd) begin
        hostWrite(DAT, d);
        hostWrite(CMD, {2'b10, 22'b0, a});
        waitIdle(cyc);
        check(cyc >= 8, "R4 busy length", cyc, 8);
        hostRead(DAT, rd); check(rd == d, "R10 data kept after write", rd, d);
        repeat (4) @(negedge hostClk);
        check(strobeCnt == base + 1, "R5 one strobe", strobeCnt, base + 1);
        check(farMem[a] == d, "R5 far write", farMem[a], d);
        refMem[a] = d;
      end else begin
        hostWrite(CMD, {2'b11, 22'b0, a});
        waitIdle(cyc);
        check(cyc >= 8, "R4 busy length", cyc, 8);
        hostRead(DAT, rd); check(rd == refMem[a], "R6 read value", rd, refMem[a]);
        hostRead(CMD, rd); check(rd == {2'b01, 22'b0, a}, "R2 read cmd", rd, {2'b01, 22'b0, a});
        repeat (4) @(negedge hostClk);
        check(strobeCnt == base + 1, "R5 one strobe", strobeCnt, base + 1);
      end
    end
    finish();
  end

endmodule